// File: doc/BRIEF.md
# Two-Wire Command and Readout Slave for a Multichannel Converter

This block is the serial front end of an eight-input, 12-bit data-acquisition converter. It watches the two bus lines (SCL and SDA) through a fast system clock and finds START and STOP conditions. It answers only to its own 7-bit address. It pulls SDA low through an open-drain enable and never stalls the bus.

A write carries one command byte. That byte holds a start marker, the channel number, the span and polarity choices, and the power mode. The block latches these fields for the converter. It pulses an acquisition strobe partway through the byte, as soon as the polarity bit is in. It pulses a conversion strobe at the STOP that closes a valid write.

A read returns the most recent converter result as two bytes: the upper eight bits first, then the lower four bits padded with four zeros. The converter core itself sits outside the block.

Top module: `adc_cmd_slave`

## Requirements
- R1: After reset the block leaves SDA released (`sda_drive` = 0). `acq_start` and `conv_start` are 0, and all command fields are 0.
- R2: The device address is binary 0101 in the upper four bits and `addr_strap` in the lower three. The eighth address bit is the direction: 0 means write, 1 means read. On a match the block drives SDA low during the ninth SCL clock, for both directions. On a mismatch it never acknowledges and ignores the bus until the next START or STOP.
- R3: A command byte whose first bit (bit 7) is 1 is acknowledged on the ninth clock. The block latches the fields: `chan_sel` = bits 6..4, `range_sel` = bit 3, `bipolar_sel` = bit 2, `pwr_mode` = bits 1..0. `pwr_mode` changes only after the eighth data bit.
- R4: A command byte whose first bit is 0 is not acknowledged. It changes no field and fires no strobe.
- R5: `acq_start` is a one-cycle pulse. It fires once the SCL rise carrying bit 2 of a valid command byte has been seen, before the bit-1 clock. `chan_sel`, `range_sel` and `bipolar_sel` change only in the cycle where `acq_start` is high.
- R6: `conv_start` is a one-cycle pulse that follows a STOP. It fires only when a valid command byte was received since the last START. A repeated START discards the pending conversion.
- R7: A read sends `result[11:4]` MSB first. If the master acknowledges, the block then sends `result[3:0]` followed by four zero bits.
- R8: After the master answers a read byte with NACK, or acknowledges the second byte, the block keeps SDA released until the next START or STOP.
- R9: The block releases SDA at every START and STOP. Apart from those, it changes its SDA drive only while the synchronized SCL is low.
- R10: The 12-bit value sent in a read is captured when the address acknowledge ends. A change on `result` during the read does not alter the bytes being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 3 | Strap value for the low three address bits |
| result | input | 12 | Latest converter result |
| sda_drive | output | 1 | 1 pulls SDA low (open-drain enable) |
| chan_sel | output | 3 | Latched channel number |
| range_sel | output | 1 | Latched span choice |
| bipolar_sel | output | 1 | Latched polarity choice |
| pwr_mode | output | 2 | Latched power mode |
| acq_start | output | 1 | One-cycle acquisition-start pulse |
| conv_start | output | 1 | One-cycle conversion-start pulse |

## Verification
A repeated START can land while a valid write is still waiting for its STOP. In that moment, START detection and the pending-conversion flag act on the same cycle. The bench forces this case: it sends a valid command, then a repeated START and a full read, then a STOP. It then checks two things: that the conversion count is unchanged, and that the read bytes are still correct. The bench also checks, bit by bit, that the acquisition pulse and the three field updates land together in the cycle after the polarity bit's clock rise. It confirms that the power mode has not moved yet at that point.

// File: rtl/adc_slave_pkg.sv
package adc_slave_pkg;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 3;
  localparam int PD_W     = 2;
  localparam int STRAP_W  = 3;
  localparam int FRAME_W  = 16;
  localparam logic [3:0] ADDR_FIXED = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_C,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } slv_st_e;
endpackage

// File: rtl/adc_line_sync.sv
module adc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q, sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
          end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data line moves while clock is steadily high: bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_slave_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_cmd,
  input  logic [SEL_W-1:0] sel_d,
  input  logic             rng_d,
  input  logic             bip_d,
  input  logic             ld_pd,
  input  logic [PD_W-1:0]  pd_d,
  output logic [SEL_W-1:0] chan_sel,
  output logic             range_sel,
  output logic             bipolar_sel,
  output logic [PD_W-1:0]  pwr_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_sel    <= '0;
      range_sel   <= 1'b0;
      bipolar_sel <= 1'b0;
    end else if (ld_cmd) begin
      chan_sel    <= sel_d;
      range_sel   <= rng_d;
      bipolar_sel <= bip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pwr_mode <= '0;
    else if (ld_pd) pwr_mode <= pd_d;
  end
endmodule

// File: rtl/adc_cmd_slave.sv
module adc_cmd_slave
  import adc_slave_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int SYNC_N = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [RES_W-1:0]   result,
  output logic               sda_drive,
  output logic [SEL_W-1:0]   chan_sel,
  output logic               range_sel,
  output logic               bipolar_sel,
  output logic [PD_W-1:0]    pwr_mode,
  output logic               acq_start,
  output logic               conv_start
);
  localparam int PAD_W = FRAME_W - RES_W;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] BIP_BIT  = 4'(BYTE_W - 3);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  adc_line_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  slv_st_e           st, st_n;
  logic [3:0]        cnt, cnt_n;
  logic [6:0]        sh, sh_n;
  logic [7:0]        tx, tx_n;
  logic [7:0]        lo, lo_n;
  logic              rw, rw_n;
  logic              ack_on, ack_on_n;
  logic              second, second_n;
  logic              wr_ok, wr_ok_n;
  logic              drive, drive_n;
  logic              acq_n, conv_n, ld_pd;
  logic [FRAME_W-1:0] tx_word;
  logic [7:0]        rx_byte;

  assign tx_word = FRAME_W'(result) << PAD_W;
  assign rx_byte = {sh, sda_s};

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; tx_n = tx; lo_n = lo; rw_n = rw;
    ack_on_n = ack_on; second_n = second; wr_ok_n = wr_ok; drive_n = drive;
    acq_n = 1'b0; conv_n = 1'b0; ld_pd = 1'b0;
    if (start_det) begin
      st_n = ST_ADDR; cnt_n = '0; drive_n = 1'b0; ack_on_n = 1'b0; wr_ok_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE; drive_n = 1'b0; ack_on_n = 1'b0;
      conv_n = wr_ok; wr_ok_n = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: if (scl_rise) begin
          sh_n  = {sh[5:0], sda_s};
          cnt_n = cnt + 4'd1;
          if (cnt == LAST_BIT) begin
            rw_n = sda_s;
            st_n = (rx_byte[7:1] == {ADDR_FIXED, addr_strap}) ? ST_ACK_A : ST_SKIP;
          end
        end
        ST_ACK_A: if (scl_fall) begin
          if (!ack_on) begin
            drive_n = 1'b1; ack_on_n = 1'b1;
          end else begin
            ack_on_n = 1'b0; cnt_n = '0;
            if (rw) begin
              tx_n = tx_word[15:8]; lo_n = tx_word[7:0];
              drive_n = ~tx_word[15]; second_n = 1'b0; st_n = ST_RD;
            end else begin
              drive_n = 1'b0; st_n = ST_WR;
            end
          end
        end
        ST_WR: if (scl_rise) begin
          sh_n  = {sh[5:0], sda_s};
          cnt_n = cnt + 4'd1;
          if (cnt == BIP_BIT && sh[4]) acq_n = 1'b1;
          if (cnt == LAST_BIT) begin
            if (sh[6]) begin
              ld_pd = 1'b1; wr_ok_n = 1'b1; st_n = ST_ACK_C;
            end else begin
              st_n = ST_SKIP;
            end
          end
        end
        ST_ACK_C: if (scl_fall) begin
          if (!ack_on) begin
            drive_n = 1'b1; ack_on_n = 1'b1;
          end else begin
            drive_n = 1'b0; ack_on_n = 1'b0; st_n = ST_SKIP;
          end
        end
        ST_RD: begin
          if (scl_rise) cnt_n = cnt + 4'd1;
          if (scl_fall) begin
            if (cnt == 4'(BYTE_W)) begin
              drive_n = 1'b0; st_n = ST_RD_ACK;
            end else begin
              tx_n = {tx[6:0], 1'b0}; drive_n = ~tx[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) ack_on_n = ~sda_s & ~second;
          if (scl_fall) begin
            if (ack_on) begin
              tx_n = lo; drive_n = ~lo[7]; second_n = 1'b1;
              cnt_n = '0; ack_on_n = 1'b0; st_n = ST_RD;
            end else begin
              st_n = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; lo <= '0; rw <= 1'b0;
      ack_on <= 1'b0; second <= 1'b0; wr_ok <= 1'b0; drive <= 1'b0;
      acq_start <= 1'b0; conv_start <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; tx <= tx_n; lo <= lo_n; rw <= rw_n;
      ack_on <= ack_on_n; second <= second_n; wr_ok <= wr_ok_n; drive <= drive_n;
      acq_start <= acq_n; conv_start <= conv_n;
    end
  end

  assign sda_drive = drive;

  adc_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .ld_cmd(acq_n), .sel_d(sh[3:1]), .rng_d(sh[0]), .bip_d(sda_s),
    .ld_pd(ld_pd), .pd_d({sh[0], sda_s}),
    .chan_sel(chan_sel), .range_sel(range_sel),
    .bipolar_sel(bipolar_sel), .pwr_mode(pwr_mode)
  );
endmodule

// File: rtl/adc_cmd_slave_chk.sv
module adc_cmd_slave_chk
  import adc_slave_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_drive,
  input logic             acq_start,
  input logic             conv_start,
  input logic [SEL_W-1:0] chan_sel,
  input logic             range_sel,
  input logic             bipolar_sel
);
  AST_ACQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> !acq_start); // R5

  AST_FIELDS_WITH_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(chan_sel) || !$stable(range_sel) || !$stable(bipolar_sel)) |-> acq_start); // R5

  AST_CONV_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(stop_det)); // R6

  AST_CONV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R6

  AST_RELEASE_ON_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_drive); // R9

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_drive) && !$past(start_det || stop_det)) |-> !scl_s); // R9
endmodule

bind adc_cmd_slave adc_cmd_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_drive(sda_drive), .acq_start(acq_start),
  .conv_start(conv_start), .chan_sel(chan_sel), .range_sel(range_sel),
  .bipolar_sel(bipolar_sel)
);

// File: tb/adc_cmd_slave_bench.sv
module adc_cmd_slave_bench;
  logic        clk, rst_n, scl, sda_m, sda_bus;
  logic [2:0]  strap;
  logic [11:0] res;
  logic        sda_drive, range_sel, bipolar_sel, acq_start, conv_start;
  logic [2:0]  chan_sel;
  logic [1:0]  pwr_mode;
  int          vec_cnt, err_cnt, acq_cnt, conv_cnt;
  bit          done;

  assign sda_bus = sda_m & ~sda_drive;

  adc_cmd_slave u_adc_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .addr_strap(strap),
    .result(res), .sda_drive(sda_drive), .chan_sel(chan_sel), .range_sel(range_sel),
    .bipolar_sel(bipolar_sel), .pwr_mode(pwr_mode), .acq_start(acq_start),
    .conv_start(conv_start)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (acq_start)  acq_cnt++;
    if (conv_start) conv_cnt++;
  end

  task automatic check(input string tag, input int act, input int exp);
    vec_cnt++;
    if (act != exp) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 1'b0; hw(4); sda_m = 1'b1; hw(4); scl = 1'b1; hw(6); sda_m = 1'b0; hw(6);
  endtask

  task automatic bus_stop();
    scl = 1'b0; hw(4); sda_m = 1'b0; hw(4); scl = 1'b1; hw(6); sda_m = 1'b1; hw(6);
  endtask

  task automatic put_bit(input logic b, output logic seen);
    scl = 1'b0; hw(4); sda_m = b; hw(4); scl = 1'b1; hw(4); seen = sda_bus; hw(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i], x);
    put_bit(1'b1, ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(1'b1, d[i]);
    put_bit(mack, x);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    logic       ack, x;
    logic [7:0] d;
    logic [1:0] pd_prev;
    int         a0, c0;
    vec_cnt = 0; err_cnt = 0; acq_cnt = 0; conv_cnt = 0; done = 0;
    scl = 1'b1; sda_m = 1'b1; strap = 3'd0; res = 12'h000; rst_n = 1'b0;
    hw(5); rst_n = 1'b1; hw(6);

    // R1 reset state
    check("R1 sda_drive", sda_drive, 0);
    check("R1 chan_sel", chan_sel, 0);
    check("R1 range/bip", {range_sel, bipolar_sel}, 0);
    check("R1 pwr_mode", pwr_mode, 0);
    check("R1 strobes", acq_cnt + conv_cnt, 0);

    // R2 strap x address sweep, write direction
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 8; a++) begin
        strap = 3'(s);
        bus_start();
        send_byte({4'b0101, 3'(a), 1'b0}, ack);
        check("R2 address ack", ack, (a == s) ? 0 : 1);
        bus_stop();
      end
    end
    check("R6 no conv without command", conv_cnt, 0);

    // R2 wrong fixed nibble, then data ignored
    strap = 3'd3;
    bus_start();
    send_byte({4'b1101, 3'd3, 1'b0}, ack);
    check("R2 fixed nibble mismatch", ack, 1);
    send_byte(8'hBF, ack);
    check("R2 ignored byte no ack", ack, 1);
    check("R2 ignored byte no acq", acq_cnt, 0);
    bus_stop();
    check("R2 ignored byte no conv", conv_cnt, 0);

    // R3 R5 R6 command byte sweep
    for (int v = 0; v < 128; v++) begin
      logic [7:0] cb;
      cb = {1'b1, 7'(v)};
      a0 = acq_cnt; c0 = conv_cnt; pd_prev = pwr_mode;
      bus_start();
      send_byte({4'b0101, 3'd3, 1'b0}, ack);
      check("R2 write ack", ack, 0);
      for (int i = 7; i >= 2; i--) put_bit(cb[i], x);
      check("R5 acq after bit2", acq_cnt, a0 + 1);
      check("R5 fields at acq", {chan_sel, range_sel, bipolar_sel}, cb[6:2]);
      check("R3 pwr_mode not yet", pwr_mode, pd_prev);
      put_bit(cb[1], x); put_bit(cb[0], x);
      put_bit(1'b1, ack);
      check("R3 command ack", ack, 0);
      check("R3 pwr_mode", pwr_mode, cb[1:0]);
      check("R6 no conv before stop", conv_cnt, c0);
      bus_stop();
      check("R6 conv at stop", conv_cnt, c0 + 1);
      check("R9 released after stop", sda_drive, 0);
    end

    // R4 first bit zero
    a0 = acq_cnt; c0 = conv_cnt;
    bus_start();
    send_byte({4'b0101, 3'd3, 1'b0}, ack);
    send_byte(8'h40, ack);
    check("R4 no ack", ack, 1);
    check("R4 fields unchanged", {chan_sel, range_sel, bipolar_sel, pwr_mode}, 7'h7F);
    check("R4 no acq", acq_cnt, a0);
    bus_stop();
    check("R4 no conv", conv_cnt, c0);

    // R6 repeated START discards pending conversion, then read
    res = 12'hA5C;
    c0 = conv_cnt;
    bus_start();
    send_byte({4'b0101, 3'd3, 1'b0}, ack);
    send_byte(8'h9A, ack);
    check("R3 command ack before Sr", ack, 0);
    bus_start();
    send_byte({4'b0101, 3'd3, 1'b1}, ack);
    check("R2 read ack after Sr", ack, 0);
    recv_byte(1'b0, d);
    check("R7 high byte after Sr", d, 8'hA5);
    recv_byte(1'b1, d);
    check("R7 low byte after Sr", d, 8'hC0);
    bus_stop();
    check("R6 Sr discards conv", conv_cnt, c0);

    // R7 R8 R10 read sweep with result changing mid-read
    for (int k = 0; k < 16; k++) begin
      logic [11:0] r;
      r = 12'((k * 12'h1A7 + 12'h035) & 12'hFFF);
      res = r;
      bus_start();
      send_byte({4'b0101, 3'd3, 1'b1}, ack);
      check("R2 read ack", ack, 0);
      recv_byte(1'b0, d);
      check("R7 high byte", d, r[11:4]);
      res = ~r;
      recv_byte(1'b1, d);
      check("R10 low byte from snapshot", d, {r[3:0], 4'b0000});
      put_bit(1'b1, x);
      check("R8 released after NACK", x, 1);
      bus_stop();
    end

    // R8 NACK on first byte: nothing more driven
    res = 12'h000;
    bus_start();
    send_byte({4'b0101, 3'd3, 1'b1}, ack);
    recv_byte(1'b1, d);
    check("R7 zero high byte", d, 8'h00);
    recv_byte(1'b1, d);
    check("R8 no second byte after NACK", d, 8'hFF);
    bus_stop();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule